// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Port

This block lets an internal bus read an external serial flash as if it were a read-only memory region. A bus master presents an address and an access size (byte, halfword or word). The port checks the request against the enable input and the configured device size. A legal request is broken into single-byte fetch requests toward a serial read sequencer, and the returned bytes are assembled into one little-endian response. An illegal request is answered at once with an error flag and zero data.

The address window is fixed at 28 bits (256 MB). The device size is set as a power of two, 2^(exp+1) bytes. Any address at or above that size, but still inside the window, is rejected.

After each successful access the port fetches, on its own, the byte that follows the last byte it delivered and holds it in a one-entry buffer. When the next access starts at that address, the first byte comes from the buffer and no fetch is needed for it. A non-sequential access leaves any prefetch that is still in flight to finish. The stale response is absorbed into the buffer under its own address, and the new access then proceeds normally.

Top module: `flash_mmap_port`

## Requirements
- R1: While reset is held the port shows `bus_req_ready`=1, `bus_rsp_valid`=0 and `fetch_req_valid`=0.
- R2: A byte read (`bus_req_size`=2'b00) returns the flash byte in bits [7:0] with bits [31:8] zero. Each response is a single-cycle `bus_rsp_valid` pulse.
- R3: A halfword read (2'b01) or word read (2'b10) returns consecutive flash bytes in little-endian order: the byte at the request address sits in bits [7:0].
- R4: With `cfg_size_exp`=e<27, an address >= 2^(e+1) is answered with `bus_rsp_err`=1 and zero data. With e>=27 the whole 28-bit window is valid.
- R5: While `cfg_en`=0 every access is answered with an error and zero data.
- R6: Size code 2'b11, a halfword at an odd address, and a word at an address not divisible by four are all answered with an error.
- R7: A rejected request accepted while no prefetch is outstanding gets its response in the cycle right after acceptance, and it issues no fetch.
- R8: After a successful access the port issues exactly one prefetch, for the address one past the last byte delivered.
- R9: A byte read that hits the prefetched address responds two cycles after acceptance and issues no fetch. A wider hit fetches only the remaining bytes.
- R10: No fetch is ever issued for an address at or beyond the configured size. The last byte of the device is therefore not followed by a prefetch.
- R11: A read that does not start at the prefetched address still returns correct data, taking more than two cycles.
- R12: A fetch request for a bus access holds its valid flag and address until the sequencer accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_size_exp | input | 5 | Device size exponent, size = 2^(value+1) bytes |
| bus_req_valid | input | 1 | Read request valid |
| bus_req_ready | output | 1 | Port can accept a read request |
| bus_req_addr | input | 28 | Byte address of the read |
| bus_req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| bus_rsp_valid | output | 1 | Response pulse |
| bus_rsp_err | output | 1 | Response is an error |
| bus_rsp_data | output | 32 | Little-endian read data, zero on error |
| fetch_req_valid | output | 1 | Byte fetch request valid |
| fetch_req_ready | input | 1 | Sequencer accepts the fetch |
| fetch_req_addr | output | 28 | Address of the byte to fetch |
| fetch_rsp_valid | input | 1 | Fetched byte valid |
| fetch_rsp_data | input | 8 | Fetched byte |

## Verification
The assertions take for granted four things about the inputs:
- the enable and size inputs stay still while an access or a prefetch is in progress;
- the sequencer returns exactly one byte for each accepted fetch;
- the sequencer sends no response when nothing is outstanding;
- the bus takes each response pulse in the cycle it is shown.

The bench's sequencer model keeps a single outstanding fetch and withholds ready while one is pending. The bench alters configuration only after an idle gap long enough for any prefetch to finish. It mixes gap-free request streams with idle gaps, so that prefetches in flight, cancelled prefetches and buffer hits all occur.

// File: rtl/flash_mmap_pkg.sv
package flash_mmap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_WAIT,
    ST_RESP,
    ST_PF_REQ,
    ST_PF_WAIT,
    ST_DRAIN
  } port_state_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/flash_addr_check.sv
module flash_addr_check
  import flash_mmap_pkg::*;
#(
  parameter int unsigned AW = 28,
  parameter int unsigned EW = 5
) (
  input  logic          en_i,
  input  logic [EW-1:0] size_exp_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          err_o
);

  localparam logic [EW:0] FULL_SPAN = (EW+1)'(AW);

  logic [EW:0] span;
  logic        in_range;
  logic        misal;

  always_comb begin
    span = {1'b0, size_exp_i} + (EW+1)'(1);
    if (span > FULL_SPAN) span = FULL_SPAN;
    in_range = (span == FULL_SPAN) || ((addr_i >> span) == '0);
    case (size_i)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = addr_i[0];
      SZ_WORD: misal = |addr_i[1:0];
      default: misal = 1'b1;
    endcase
    err_o = !en_i || !in_range || misal;
  end

endmodule

// File: rtl/flash_pf_buffer.sv
module flash_pf_buffer #(
  parameter int unsigned AW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [7:0]    load_data_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          hit_o,
  output logic [7:0]    data_o
);

  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          upd_en;

  always_comb begin
    upd_en  = load_i && !clr_i;
    valid_d = valid_q;
    if (clr_i)       valid_d = 1'b0;
    else if (load_i) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (upd_en) begin
        addr_q <= load_addr_i;
        data_q <= load_data_i;
      end
    end
  end

  assign hit_o  = valid_q && (addr_q == look_addr_i);
  assign data_o = data_q;

endmodule

// File: rtl/flash_mmap_port.sv
module flash_mmap_port
  import flash_mmap_pkg::*;
#(
  parameter int unsigned AW = 28,
  parameter int unsigned EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [EW-1:0] cfg_size_exp,
  input  logic          bus_req_valid,
  output logic          bus_req_ready,
  input  logic [AW-1:0] bus_req_addr,
  input  logic [1:0]    bus_req_size,
  output logic          bus_rsp_valid,
  output logic          bus_rsp_err,
  output logic [31:0]   bus_rsp_data,
  output logic          fetch_req_valid,
  input  logic          fetch_req_ready,
  output logic [AW-1:0] fetch_req_addr,
  input  logic          fetch_rsp_valid,
  input  logic [7:0]    fetch_rsp_data
);

  port_state_t   st_q, st_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic [1:0]    idx_q, idx_d;
  logic [1:0]    last_q, last_d;
  logic [31:0]   acc_q, acc_d;
  logic          err_q, err_d;

  logic          req_err;
  logic [1:0]    req_last;
  logic [AW:0]   nxt_full;
  logic          nxt_err;
  logic          hit;
  logic [7:0]    pf_data;
  logic          pf_load;
  logic          acc_req;
  logic          take;
  logic [7:0]    take_byte;

  flash_addr_check #(.AW(AW), .EW(EW)) u_req_chk (
    .en_i       (cfg_en),
    .size_exp_i (cfg_size_exp),
    .addr_i     (bus_req_addr),
    .size_i     (bus_req_size),
    .err_o      (req_err)
  );

  assign nxt_full = {1'b0, cur_q} + (AW+1)'(1);

  flash_addr_check #(.AW(AW), .EW(EW)) u_nxt_chk (
    .en_i       (cfg_en),
    .size_exp_i (cfg_size_exp),
    .addr_i     (nxt_full[AW-1:0]),
    .size_i     (SZ_BYTE),
    .err_o      (nxt_err)
  );

  flash_pf_buffer #(.AW(AW)) u_pf (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (!cfg_en),
    .load_i      (pf_load),
    .load_addr_i (tgt_q),
    .load_data_i (fetch_rsp_data),
    .look_addr_i (cur_q),
    .hit_o       (hit),
    .data_o      (pf_data)
  );

  // Port-side decode.
  always_comb begin
    bus_req_ready   = (st_q == ST_IDLE) || (st_q == ST_PF_REQ) || (st_q == ST_PF_WAIT);
    acc_req         = bus_req_valid && bus_req_ready;
    fetch_req_valid = ((st_q == ST_GATHER) && !hit) ||
                      ((st_q == ST_PF_REQ) && !bus_req_valid && cfg_en);
    fetch_req_addr  = (st_q == ST_PF_REQ) ? tgt_q : cur_q;
    pf_load         = fetch_rsp_valid && ((st_q == ST_PF_WAIT) || (st_q == ST_DRAIN));
    take            = ((st_q == ST_GATHER) && hit) || ((st_q == ST_WAIT) && fetch_rsp_valid);
    take_byte       = (st_q == ST_GATHER) ? pf_data : fetch_rsp_data;
    bus_rsp_valid   = (st_q == ST_RESP);
    bus_rsp_err     = (st_q == ST_RESP) && err_q;
    bus_rsp_data    = ((st_q == ST_RESP) && !err_q) ? acc_q : '0;
    case (bus_req_size)
      SZ_HALF: req_last = 2'd1;
      SZ_WORD: req_last = 2'd3;
      default: req_last = 2'd0;
    endcase
  end

  // Next-state logic.
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    tgt_d  = tgt_q;
    idx_d  = idx_q;
    last_d = last_q;
    acc_d  = acc_q;
    err_d  = err_q;

    if (acc_req) begin
      cur_d  = bus_req_addr;
      idx_d  = 2'd0;
      last_d = req_last;
      err_d  = req_err;
      acc_d  = '0;
    end

    case (st_q)
      ST_IDLE: begin
        if (acc_req) st_d = req_err ? ST_RESP : ST_GATHER;
      end
      ST_PF_REQ: begin
        if (acc_req)              st_d = req_err ? ST_RESP : ST_GATHER;
        else if (!cfg_en)         st_d = ST_IDLE;
        else if (fetch_req_ready) st_d = ST_PF_WAIT;
      end
      ST_PF_WAIT: begin
        if (fetch_rsp_valid) begin
          if (acc_req) st_d = req_err ? ST_RESP : ST_GATHER;
          else         st_d = ST_IDLE;
        end else if (acc_req) begin
          st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (fetch_rsp_valid) st_d = err_q ? ST_RESP : ST_GATHER;
      end
      ST_GATHER: begin
        if (!hit && fetch_req_ready) st_d = ST_WAIT;
      end
      ST_RESP: begin
        if (!err_q && !nxt_err && !nxt_full[AW]) begin
          st_d  = ST_PF_REQ;
          tgt_d = nxt_full[AW-1:0];
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = st_q;
    endcase

    if (take) begin
      acc_d[{idx_q, 3'b000} +: 8] = take_byte;
      if (idx_q == last_q) begin
        st_d = ST_RESP;
      end else begin
        idx_d = idx_q + 2'd1;
        cur_d = cur_q + AW'(1);
        st_d  = ST_GATHER;
      end
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      tgt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      acc_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      acc_q  <= acc_d;
      err_q  <= err_d;
      if (st_q == ST_RESP) tgt_q <= tgt_d;
    end
  end

  // R7
  err_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && req_err && (st_q != ST_PF_WAIT)) |=> (bus_rsp_valid && bus_rsp_err));

  // R9
  pf_hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GATHER) && hit && (idx_q == last_q)) |=> (bus_rsp_valid && !bus_rsp_err));

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GATHER) && fetch_req_valid && !fetch_req_ready)
      |=> (fetch_req_valid && $stable(fetch_req_addr)));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid |=> !bus_rsp_valid);

endmodule

// File: tb/flash_mmap_port_tb.sv
module flash_mmap_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_en;
  logic [4:0]  cfg_size_exp;
  logic        bus_req_valid;
  logic        bus_req_ready;
  logic [27:0] bus_req_addr;
  logic [1:0]  bus_req_size;
  logic        bus_rsp_valid;
  logic        bus_rsp_err;
  logic [31:0] bus_rsp_data;
  logic        fetch_req_valid;
  logic        fetch_req_ready;
  logic [27:0] fetch_req_addr;
  logic        fetch_rsp_valid;
  logic [7:0]  fetch_rsp_data;

  int checks;
  int errors;
  int fetch_cnt;
  logic [27:0] last_fetch;
  bit   done;

  flash_mmap_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_size_exp(cfg_size_exp),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_addr(bus_req_addr), .bus_req_size(bus_req_size),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err), .bus_rsp_data(bus_rsp_data),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_data(fetch_rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem_b(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ {4'h0, a[27:24]} ^ 8'h3C;
  endfunction

  function automatic logic exp_err(input logic [27:0] a, input logic [1:0] sz,
                                   input logic en, input logic [4:0] ex);
    logic misal;
    misal = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    if (!en || misal) return 1'b1;
    if (ex >= 5'd27) return 1'b0;
    return 64'(a) >= (64'd1 << (ex + 5'd1));
  endfunction

  function automatic logic [31:0] exp_data(input logic [27:0] a, input logic [1:0] sz);
    logic [31:0] d;
    int n;
    d = '0;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    for (int i = 0; i < n; i++) d[i*8 +: 8] = mem_b(a + 28'(i));
    return d;
  endfunction

  function automatic longint lim_of(input logic [4:0] ex);
    if (ex >= 5'd27) return 64'd1 << 28;
    return 64'd1 << (ex + 5'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Sequencer model: one outstanding fetch, 1..4 cycle latency.
  initial begin : seq_model
    bit pend;
    int cnt;
    logic [27:0] paddr;
    pend = 0; cnt = 0; paddr = '0;
    fetch_req_ready = 1'b0; fetch_rsp_valid = 1'b0; fetch_rsp_data = '0;
    fetch_cnt = 0; last_fetch = '0;
    forever begin
      @(negedge clk);
      fetch_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          fetch_rsp_valid = 1'b1;
          fetch_rsp_data  = mem_b(paddr);
          pend = 0;
        end else cnt--;
      end
      fetch_req_ready = !pend && (($urandom % 4) != 0);
      #8;
      if (rst_n && fetch_req_valid && fetch_req_ready) begin
        pend = 1; paddr = fetch_req_addr; cnt = int'($urandom % 4);
        fetch_cnt++; last_fetch = fetch_req_addr;
        // R10: no fetch beyond configured size
        chk(64'(fetch_req_addr) < lim_of(cfg_size_exp), "R10 fetch in range",
            32'(fetch_req_addr), 32'(lim_of(cfg_size_exp)));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [27:0] a, input logic [1:0] sz,
                    output logic [31:0] d, output logic e, output int lat);
    @(negedge clk);
    bus_req_valid = 1'b1; bus_req_addr = a; bus_req_size = sz;
    #8;
    while (!bus_req_ready) begin @(negedge clk); #8; end
    @(negedge clk);
    bus_req_valid = 1'b0;
    lat = 1;
    #8;
    while (!bus_rsp_valid && lat < 1000) begin @(negedge clk); #8; lat++; end
    d = bus_rsp_data; e = bus_rsp_err;
  endtask

  task automatic set_cfg(input logic en, input logic [4:0] ex);
    idle(40);
    cfg_en = en; cfg_size_exp = ex;
    idle(2);
  endtask

  task automatic rd_chk(input logic [27:0] a, input logic [1:0] sz, input string req);
    logic [31:0] d; logic e; int lat;
    logic xe;
    rd(a, sz, d, e, lat);
    xe = exp_err(a, sz, cfg_en, cfg_size_exp);
    chk(e == xe, {req, " err flag"}, 32'(e), 32'(xe));
    chk(d == (xe ? 32'h0 : exp_data(a, sz)), {req, " data"}, d, xe ? 32'h0 : exp_data(a, sz));
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d; logic e; int lat; int f0;
    logic [27:0] prev;
    void'($urandom(32'd20240611));
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_size_exp = 5'd15;
    bus_req_valid = 1'b0; bus_req_addr = '0; bus_req_size = '0;
    idle(4);
    // R1 reset state
    chk(bus_req_ready == 1'b1, "R1 ready", 32'(bus_req_ready), 1);
    chk(bus_rsp_valid == 1'b0, "R1 rsp_valid", 32'(bus_rsp_valid), 0);
    chk(fetch_req_valid == 1'b0, "R1 fetch_valid", 32'(fetch_req_valid), 0);
    rst_n = 1'b1;
    set_cfg(1'b1, 5'd15);

    // R2 / R8: byte read then prefetch of next address
    f0 = fetch_cnt;
    rd(28'h100, 2'b00, d, e, lat);
    chk(d == exp_data(28'h100, 2'b00) && !e, "R2 byte data", d, exp_data(28'h100, 2'b00));
    idle(30);
    chk(fetch_cnt - f0 == 2, "R8 one prefetch", 32'(fetch_cnt - f0), 2);
    chk(last_fetch == 28'h101, "R8 prefetch addr", 32'(last_fetch), 32'h101);

    // R9 byte hit
    f0 = fetch_cnt;
    rd(28'h101, 2'b00, d, e, lat);
    chk(lat == 2, "R9 hit latency", 32'(lat), 2);
    chk(fetch_cnt == f0, "R9 hit no fetch", 32'(fetch_cnt - f0), 0);
    chk(d == exp_data(28'h101, 2'b00), "R2 hit data", d, exp_data(28'h101, 2'b00));
    idle(30);

    // R3 / R9 halfword hit: one fetch
    f0 = fetch_cnt;
    rd(28'h102, 2'b01, d, e, lat);
    chk(fetch_cnt - f0 == 1, "R9 half hit fetches", 32'(fetch_cnt - f0), 1);
    chk(d == exp_data(28'h102, 2'b01), "R3 half data", d, exp_data(28'h102, 2'b01));
    idle(30);

    // R3 / R9 word hit: three fetches
    f0 = fetch_cnt;
    rd(28'h104, 2'b10, d, e, lat);
    chk(fetch_cnt - f0 == 3, "R9 word hit fetches", 32'(fetch_cnt - f0), 3);
    chk(d == exp_data(28'h104, 2'b10), "R3 word data", d, exp_data(28'h104, 2'b10));
    idle(30);

    // R11 non-sequential
    rd(28'h2000, 2'b00, d, e, lat);
    chk(lat > 2, "R11 miss latency", 32'(lat), 3);
    chk(d == exp_data(28'h2000, 2'b00), "R11 data", d, exp_data(28'h2000, 2'b00));
    idle(30);

    // R4 / R7 out of range, fast error, no fetch
    f0 = fetch_cnt;
    rd(28'h10000, 2'b00, d, e, lat);
    chk(e == 1'b1, "R4 range err", 32'(e), 1);
    chk(d == 32'h0, "R4 err data zero", d, 0);
    chk(lat == 1, "R7 err latency", 32'(lat), 1);
    chk(fetch_cnt == f0, "R7 no fetch", 32'(fetch_cnt - f0), 0);
    rd_chk(28'hFFFC, 2'b10, "R4 top word");
    idle(30);

    // R10 last byte: no prefetch follows
    f0 = fetch_cnt;
    rd(28'hFFFF, 2'b00, d, e, lat);
    idle(30);
    chk(fetch_cnt - f0 == 1, "R10 no prefetch past end", 32'(fetch_cnt - f0), 1);
    chk(d == exp_data(28'hFFFF, 2'b00), "R2 last byte", d, exp_data(28'hFFFF, 2'b00));

    // R6 misaligned and illegal size
    rd_chk(28'h101, 2'b01, "R6 odd half");
    rd_chk(28'h102, 2'b10, "R6 misaligned word");
    rd_chk(28'h100, 2'b11, "R6 size code 3");

    // R5 disabled
    set_cfg(1'b0, 5'd15);
    rd_chk(28'h10, 2'b00, "R5 disabled");
    rd(28'h20, 2'b10, d, e, lat);
    chk(e == 1'b1, "R5 disabled err", 32'(e), 1);

    // R4 full window
    set_cfg(1'b1, 5'd27);
    rd_chk(28'hFFFFFFC, 2'b10, "R4 full window");
    set_cfg(1'b1, 5'd31);
    rd_chk(28'hFFFFFFF, 2'b00, "R4 exp above window");

    // Random mix
    prev = '0;
    for (int blk = 0; blk < 12; blk++) begin
      set_cfg(($urandom % 10) != 0, 5'(4 + ($urandom % 28)));
      for (int k = 0; k < 40; k++) begin
        longint lim; longint span; logic [27:0] a; logic [1:0] sz;
        lim = lim_of(cfg_size_exp);
        span = (lim * 2 > (64'd1 << 28)) ? (64'd1 << 28) : lim * 2;
        sz = 2'($urandom % 4);
        if (($urandom % 10) == 0) sz = 2'b11; else if (sz == 2'b11) sz = 2'b00;
        if (($urandom % 3) == 0) begin
          a = prev + 28'd1; sz = 2'b00;
        end else if (($urandom % 4) == 0) begin
          a = 28'(lim - 1 - longint'($urandom % 8));
        end else begin
          a = 28'(longint'({$urandom, $urandom}) % span);
        end
        if (($urandom % 5) != 0) begin
          if (sz == 2'b01) a[0] = 1'b0;
          if (sz == 2'b10) a[1:0] = 2'b00;
        end
        rd_chk(a, sz, "R2 R3 R4 R6 random");
        prev = a + ((sz == 2'b10) ? 28'd3 : (sz == 2'b01) ? 28'd1 : 28'd0);
        if (($urandom % 2) == 0) idle(int'($urandom % 7));
      end
    end

    idle(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule